// File: doc/BRIEF.md
# Indirect-Addressed Host Register Port

This block lets a host microprocessor reach a bank of internal command registers over an 8-bit parallel bus, using three active-low strobes (chip select, write, read) and one register-select line. The port is indirect. With register select low, the host reaches a pointer register. With register select high, the host reaches the command register whose index the pointer holds. To write command register N, the host first writes N with register select low. It then writes the value with register select high.

The host strobes are asynchronous to the internal clock. Every control line and the data bus pass through a two-flop synchronizer. Strobe edges are then detected on the synchronized values, so each strobe must be held for a whole number of clock periods. A write commits when the write strobe rises. The register select and data used are the synchronized values from the cycle just before that rise is seen. The bidirectional bus is modelled as a separate input, output and output-enable. A pad ring combines them into a single tristate bus.

Top module: `hpi_regport`

## Requirements
- R1: A synchronous active-high reset clears the pointer register and every command register to 00h and deasserts the output-enable. The bank has 16 command registers of 8 bits.
- R2: While chip select is high, write, read and register-select activity has no effect. No register changes and the output-enable stays low.
- R3: A write with register select low loads the bus value into the pointer register.
- R4: A write with register select high loads the bus value into the command register indexed by the pointer.
- R5: A write commits on the rising edge of the write strobe. The value stored is the last bus value present while the strobe was still low; earlier values driven during the same strobe are lost.
- R6: While chip select and read are both low, the output-enable is high and the output carries the selected register. The output-enable rises on the third clock edge after both are low.
- R7: A read with register select low returns the pointer register.
- R8: Pointer values 16 to 255 read back 00h with register select high, and writes to them change no command register.
- R9: If read and write are low at the same time, the output-enable stays low and no write takes place.
- R10: The output-enable falls on the third clock edge after read or chip select returns high, and it is still high after the second edge.
- R11: While the output-enable is low, the data output is 00h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| rs | input | 1 | Register select: 0 pointer, 1 indexed command register |
| data_in | input | 8 | Bus value seen by the block during writes |
| data_out | output | 8 | Bus value driven by the block during reads |
| data_oe | output | 1 | High while the block drives the bus |

## Verification
A corrupted pointer shows up on the very next read with register select low. It also misdirects the next command access, so the wrong register is read back or written. A command register that changes when it should not is only visible when the host next reads it. The bench therefore reads back every register it touches after each disturbing stimulus. A wrong output-enable appears at the ports within three clocks of the strobe change, and the bench checks the exact edge on every read.

// File: rtl/hpi_pkg.sv
package hpi_pkg;
  localparam int DATA_W = 8;
  localparam int PTR_W  = 8;
  localparam int SYNC_STAGES = 2;

  function automatic logic ptr_in_bank(input logic [PTR_W-1:0] ptr, input int depth);
    return int'(ptr) < depth;
  endfunction
endpackage

// File: rtl/hpi_sync.sv
module hpi_sync #(
  parameter int WIDTH = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  input  logic [WIDTH-1:0] rst_val,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= rst_val;
          else     chain[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= rst_val;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/hpi_strobe_decode.sv
module hpi_strobe_decode
  import hpi_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          wr_n,
  input  logic          rd_n,
  input  logic          rs,
  input  logic [DW-1:0] data_in,
  output logic          rd_active,
  output logic          sel_rs,
  output logic          cs_idle,
  output logic          wr_commit,
  output logic          commit_rs,
  output logic [DW-1:0] commit_data
);
  localparam int SW = 4 + DW;

  logic [SW-1:0] raw_bus, sync_bus, rst_pattern;
  logic cs_s, wr_s, rd_s, rs_s;
  logic [DW-1:0] data_s;
  logic cs_p, wr_p, rd_p, rs_p;
  logic [DW-1:0] data_p;
  logic wr_rise;

  assign raw_bus     = {cs_n, wr_n, rd_n, rs, data_in};
  assign rst_pattern = {3'b111, 1'b0, {DW{1'b0}}};

  hpi_sync #(.WIDTH(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(raw_bus), .rst_val(rst_pattern), .sync_out(sync_bus)
  );

  assign {cs_s, wr_s, rd_s, rs_s, data_s} = sync_bus;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_p <= 1'b1; wr_p <= 1'b1; rd_p <= 1'b1; rs_p <= 1'b0; data_p <= '0;
    end else begin
      cs_p <= cs_s; wr_p <= wr_s; rd_p <= rd_s; rs_p <= rs_s; data_p <= data_s;
    end
  end

  // Trailing edge of write, qualified by chip select and no read in the prior cycle
  assign wr_rise   = wr_s && !wr_p && !cs_p && rd_p;
  assign rd_active = !cs_s && !rd_s && wr_s;
  assign sel_rs    = rs_s;
  assign cs_idle   = cs_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_commit   <= 1'b0;
      commit_rs   <= 1'b0;
      commit_data <= '0;
    end else begin
      wr_commit <= wr_rise;
      if (wr_rise) begin
        commit_rs   <= rs_p;
        commit_data <= data_p;
      end
    end
  end

  AST_COMMIT_ONESHOT: assert property (@(posedge clk) disable iff (rst)
    wr_commit |=> !wr_commit); // R5
endmodule

// File: rtl/hpi_reg_bank.sv
module hpi_reg_bank
  import hpi_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = PTR_W,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_commit,
  input  logic          commit_rs,
  input  logic [DW-1:0] commit_data,
  input  logic          sel_rs,
  output logic [DW-1:0] rd_value
);
  localparam int FLAT_W = DEPTH * DW;

  logic [AW-1:0]     ptr_q;
  logic [FLAT_W-1:0] cmd_flat;

  function automatic logic [DW-1:0] pick_entry(input logic [FLAT_W-1:0] flat,
                                               input logic [AW-1:0] ptr);
    logic [DW-1:0] v;
    v = '0;
    for (int i = 0; i < DEPTH; i++)
      if (int'(ptr) == i) v = flat[i*DW +: DW];
    return v;
  endfunction

  always_ff @(posedge clk) begin
    if (rst)                        ptr_q <= '0;
    else if (wr_commit && !commit_rs) ptr_q <= AW'(commit_data);
  end

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_cmd
      always_ff @(posedge clk) begin
        if (rst)
          cmd_flat[i*DW +: DW] <= '0;
        else if (wr_commit && commit_rs && int'(ptr_q) == i)
          cmd_flat[i*DW +: DW] <= commit_data;
      end
    end
  endgenerate

  always_comb begin
    if (!sel_rs)                       rd_value = DW'(ptr_q);
    else if (ptr_in_bank(ptr_q, DEPTH)) rd_value = pick_entry(cmd_flat, ptr_q);
    else                               rd_value = '0;
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (ptr_q == '0 && cmd_flat == '0)); // R1
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(wr_commit && !commit_rs) |=> $stable(ptr_q)); // R3
  AST_OOR_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (wr_commit && !ptr_in_bank(ptr_q, DEPTH)) |=> $stable(cmd_flat)); // R8
endmodule

// File: rtl/hpi_regport.sv
module hpi_regport
  import hpi_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic              rd_n,
  input  logic              rs,
  input  logic [DATA_W-1:0] data_in,
  output logic [DATA_W-1:0] data_out,
  output logic              data_oe
);
  logic              rd_active, sel_rs, cs_idle;
  logic              wr_commit, commit_rs;
  logic [DATA_W-1:0] commit_data, rd_value;

  hpi_strobe_decode #(.DW(DATA_W)) u_decode (
    .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n), .rs(rs),
    .data_in(data_in), .rd_active(rd_active), .sel_rs(sel_rs), .cs_idle(cs_idle),
    .wr_commit(wr_commit), .commit_rs(commit_rs), .commit_data(commit_data)
  );

  hpi_reg_bank #(.DW(DATA_W), .AW(PTR_W), .DEPTH(DEPTH)) u_bank (
    .clk(clk), .rst(rst), .wr_commit(wr_commit), .commit_rs(commit_rs),
    .commit_data(commit_data), .sel_rs(sel_rs), .rd_value(rd_value)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      data_oe  <= 1'b0;
      data_out <= '0;
    end else begin
      data_oe  <= rd_active;
      data_out <= rd_active ? rd_value : '0;
    end
  end

  AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
    cs_idle |=> !data_oe); // R2
  AST_NO_WRITE_DURING_DRIVE: assert property (@(posedge clk) disable iff (rst)
    (data_oe && $past(data_oe)) |-> !wr_commit); // R9
endmodule

// File: tb/tb_hpi_regport.sv
module tb_hpi_regport;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1, rs = 1'b0;
  logic [7:0] data_in = 8'h00;
  logic [7:0] data_out;
  logic data_oe;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [7:0] exp_q [$];
  string      tag_q [$];
  logic       oe_prev = 1'b0;

  always #10 clk = ~clk;

  hpi_regport dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n), .rs(rs),
    .data_in(data_in), .data_out(data_out), .data_oe(data_oe)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Monitor: on each new drive window, pop an expected value
  always @(negedge clk) begin
    if (data_oe && !oe_prev) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R9: unexpected bus drive value %02h expected none", data_out);
      end else begin
        string t;
        logic [7:0] e;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, data_out, e);
      end
    end
    if (!data_oe) check("R11", data_out, 8'h00);
    oe_prev = data_oe;
  end

  task automatic host_write(input logic sel, input logic [7:0] v);
    cs_n = 1'b0; rs = sel; data_in = v; wr_n = 1'b0;
    cyc(4);
    wr_n = 1'b1;
    cyc(1);
    cs_n = 1'b1; data_in = 8'h00;
    cyc(6);
  endtask

  // Read with exact output-enable edge checks; expected value pushed to scoreboard
  task automatic host_read(input logic sel, input logic [7:0] exp, input string req);
    exp_q.push_back(exp);
    tag_q.push_back(req);
    cs_n = 1'b0; rs = sel; rd_n = 1'b0;
    cyc(2);
    check("R6", {7'b0, data_oe}, 8'h00);
    cyc(1);
    check("R6", {7'b0, data_oe}, 8'h01);
    cyc(3);
    rd_n = 1'b1;
    cyc(2);
    check("R10", {7'b0, data_oe}, 8'h01);
    cyc(1);
    check("R10", {7'b0, data_oe}, 8'h00);
    cs_n = 1'b1;
    cyc(4);
  endtask

  task automatic read_cmd(input logic [7:0] idx, input logic [7:0] exp, input string req);
    host_write(1'b0, idx);
    host_read(1'b1, exp, req);
  endtask

  initial begin
    #(20 * 150000);
    checks++; errors++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    finish_run();
  end

  initial begin
    cyc(4);
    rst = 1'b0;
    cyc(3);

    // R1: reset state
    check("R1", {7'b0, data_oe}, 8'h00);
    host_read(1'b0, 8'h00, "R1");
    read_cmd(8'h05, 8'h00, "R1");

    // R3 / R7: pointer write and readback
    host_write(1'b0, 8'hA7);
    host_read(1'b0, 8'hA7, "R7");
    host_write(1'b0, 8'h03);
    host_read(1'b0, 8'h03, "R3");

    // R4: command registers through the pointer
    host_write(1'b1, 8'h5C);
    host_write(1'b0, 8'h0F);
    host_write(1'b1, 8'hE1);
    host_write(1'b0, 8'h00);
    host_write(1'b1, 8'h11);
    read_cmd(8'h03, 8'h5C, "R4");
    read_cmd(8'h0F, 8'hE1, "R4");
    read_cmd(8'h00, 8'h11, "R4");

    // R5: only the value present at the strobe's trailing edge is stored
    host_write(1'b0, 8'h07);
    cs_n = 1'b0; rs = 1'b1; data_in = 8'h22; wr_n = 1'b0;
    cyc(4);
    data_in = 8'h9D;
    cyc(4);
    wr_n = 1'b1;
    cyc(1);
    cs_n = 1'b1;
    cyc(6);
    host_read(1'b1, 8'h9D, "R5");

    // R2: activity with chip select high is ignored
    cs_n = 1'b1; rs = 1'b0; data_in = 8'h44; wr_n = 1'b0;
    cyc(4); wr_n = 1'b1; cyc(6);
    rs = 1'b1; data_in = 8'h66; wr_n = 1'b0;
    cyc(4); wr_n = 1'b1; cyc(6);
    rd_n = 1'b0; cyc(6);
    check("R2", {7'b0, data_oe}, 8'h00);
    rd_n = 1'b1; cyc(4);
    host_read(1'b0, 8'h07, "R2");
    host_read(1'b1, 8'h9D, "R2");

    // R8: out-of-range pointer reads zero and ignores writes, no aliasing
    host_write(1'b0, 8'h13);
    host_write(1'b1, 8'hBB);
    host_read(1'b1, 8'h00, "R8");
    host_write(1'b0, 8'hFF);
    host_write(1'b1, 8'hCC);
    host_read(1'b1, 8'h00, "R8");
    read_cmd(8'h03, 8'h5C, "R8");

    // R9: read and write together: no drive, no write
    host_write(1'b0, 8'h03);
    cs_n = 1'b0; rs = 1'b1; data_in = 8'h77; rd_n = 1'b0; wr_n = 1'b0;
    cyc(6);
    check("R9", {7'b0, data_oe}, 8'h00);
    wr_n = 1'b1; rd_n = 1'b1;
    cyc(1); cs_n = 1'b1; cyc(6);
    check("R9", {7'b0, data_oe}, 8'h00);
    host_read(1'b1, 8'h5C, "R9");

    // R10: chip select release also ends the drive
    exp_q.push_back(8'h5C); tag_q.push_back("R10");
    cs_n = 1'b0; rs = 1'b1; rd_n = 1'b0;
    cyc(6);
    cs_n = 1'b1;
    cyc(2);
    check("R10", {7'b0, data_oe}, 8'h01);
    cyc(1);
    check("R10", {7'b0, data_oe}, 8'h00);
    rd_n = 1'b1;
    cyc(4);

    // R1: reset after activity clears everything
    rst = 1'b1; cyc(3); rst = 1'b0; cyc(3);
    check("R1", {7'b0, data_oe}, 8'h00);
    host_read(1'b0, 8'h00, "R1");
    read_cmd(8'h03, 8'h00, "R1");
    read_cmd(8'h0F, 8'h00, "R1");

    cyc(4);
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL R6: %0d reads not driven, expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule